// File: doc/BRIEF.md
# Multi-Ratio Clock Post-Divider and Output Selector

This block sits after three frequency sources (a system source, a CPU source and a utility source) and a reference clock. It builds the configurable clock outputs from them. Each source feeds a bank of fixed-ratio dividers, and each source has its own set of legal ratios. Every divider produces a clock with a 50% duty cycle. This holds for the odd ratios too, because the high phase of an odd ratio is finished on the opposite source edge.

Four general outputs each choose a source and a ratio index. Two dedicated outputs have their own small selectors: a CPU clock taken from the CPU source, and a fixed-function clock taken from the system source. A buffered copy of the reference clock is also brought out. When two outputs ask for the same source and ratio, they are fed from the same counter.

A new selection is taken up only at a falling edge of the output that is running, so a high phase that has already started always runs its full length.

Top module: `clk_post_div`

## Requirements
- R1: On a general output, source code 0 selects the system source, and the 5-bit ratio index picks the divide ratio from this ordered table: index 0 to 17 give 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104.
- R2: Source code 1 (CPU) takes indices 0 to 2 for ratios 1, 2, 4. Source code 2 (utility) takes indices 0 to 3 for ratios 1, 2, 4, 8. Source code 3 (reference) takes indices 0 to 1 for ratios 1, 2. General output n uses bits [2n+1:2n] of `cfg_src` and bits [5n+4:5n] of `cfg_idx`.
- R3: Every divided output is high for exactly half its period, odd ratios included.
- R4: On any path, an index beyond that path's table divides the chosen source by 2.
- R5: `cpu_clk` divides the CPU source by 1, 2 or 4 for `cfg_cpu_idx` equal to 0, 1 or 2, and by 2 for index 3.
- R6: `f_clk` divides the system source by 2, 3 or 4 for `cfg_f_idx` equal to 0, 1 or 2, and by 2 for index 3. It carries no phase relation to the general outputs.
- R7: `ref_buf` follows the reference clock.
- R8: A selection change is taken up only at a falling edge of the output, so the high phase in progress is never shortened.
- R9: General outputs with the same source and ratio are identical at every instant.
- R10: While `rst_n` is low, every output except `ref_buf` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sys | input | 1 | System source clock |
| clk_cpu | input | 1 | CPU source clock |
| clk_utl | input | 1 | Utility source clock |
| clk_ref | input | 1 | Reference clock |
| cfg_src | input | 8 | Source code for each general output, 2 bits each |
| cfg_idx | input | 20 | Ratio index for each general output, 5 bits each |
| cfg_cpu_idx | input | 2 | Ratio index for the CPU clock |
| cfg_f_idx | input | 2 | Ratio index for the fixed-function clock |
| gen_clk | output | 4 | General configurable clocks |
| cpu_clk | output | 1 | Divided CPU clock |
| f_clk | output | 1 | Fixed-function clock from the system source |
| ref_buf | output | 1 | Buffered reference clock |

## Verification
The bench steps through every legal source and index pair, together with several out-of-range indices, and measures both the period and the high time against the ratio computed from the tables. A divider that finished odd ratios on one edge only would show a high time half a source cycle too long. A wrong table entry or a missing fallback would show up as a wrong period. One test switches from divide-by-104 to divide-by-1 just after a rising edge; a design that took the change up at once would cut the 208 ns high phase to a runt. Further tests drive all four outputs on identical settings and then on four different sources at once, and check reset quiet, so crossed wiring between outputs and skewed duplicates are exposed.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {SRC_SYS = 2'd0, SRC_CPU = 2'd1, SRC_UTL = 2'd2, SRC_REF = 2'd3} src_e;

  localparam int NPATH = 4;
  localparam int IDXW  = 5;
  localparam int SRCW  = 2;

  function automatic int path_count(input int p);
    case (p)
      0:       return 18;
      1:       return 3;
      2:       return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int path_ratio(input int p, input int i);
    if (p != 0) return 1 << i;
    case (i)
      0: return 1;    1: return 2;    2: return 3;    3: return 4;
      4: return 5;    5: return 6;    6: return 8;    7: return 10;
      8: return 12;   9: return 13;   10: return 20;  11: return 24;
      12: return 26;  13: return 40;  14: return 48;  15: return 52;
      16: return 96;  default: return 104;
    endcase
  endfunction

  function automatic int path_base(input int p);
    int acc;
    acc = 0;
    for (int q = 0; q < p; q++) acc += path_count(q);
    return acc;
  endfunction

  localparam int NLEAF = path_base(NPATH);
  localparam int LEAFW = $clog2(NLEAF);

  // index beyond the table -> the path's divide-by-2 leaf (always index 1)
  function automatic logic [LEAFW-1:0] leaf_of(input logic [SRCW-1:0] s, input logic [IDXW-1:0] i);
    int p;
    p = int'(s);
    if (int'(i) < path_count(p)) return LEAFW'(path_base(p) + int'(i));
    return LEAFW'(path_base(p) + 1);
  endfunction

endpackage

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int N = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic div_o
);
  localparam int W   = $clog2(N);
  localparam int HI  = (N + 1) / 2;
  localparam bit ODD = (N % 2) == 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         pos_q, pos_d;

  always_comb begin
    cnt_d = (cnt_q == W'(N - 1)) ? '0 : cnt_q + 1'b1;
    pos_d = (cnt_d < W'(HI));
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(N - 1);
      pos_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  generate
    if (ODD) begin : g_odd
      logic neg_q;
      always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
      end
      assign div_o = pos_q & neg_q;

      // R3
      half_edge_track_chk: assert property (@(posedge clk_i) disable iff (!rst_n) neg_q == pos_q);
    end else begin : g_even
      assign div_o = pos_q;
    end
  endgenerate

  // checker state: edges since last rise, edges spent high
  logic [W-1:0] gap_q;
  logic [W:0]   hcnt_q;
  logic         seen_q;
  logic         rise_w;
  assign rise_w = pos_d & ~pos_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      hcnt_q <= '0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= rise_w ? '0 : gap_q + 1'b1;
      hcnt_q <= pos_d ? (pos_q ? hcnt_q + 1'b1 : (W+1)'(1)) : '0;
      seen_q <= seen_q | rise_w;
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(pos_q) && $past(seen_q)) |-> $past(gap_q) == W'(N - 1));

  // R3
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(pos_q) |-> $past(hcnt_q) == (W+1)'(HI));

endmodule

// File: rtl/div_bank.sv
module div_bank import clkdiv_pkg::*; #(
  parameter int  PATH = 0,
  localparam int NR   = path_count(PATH)
) (
  input  logic          clk_i,
  input  logic          rst_n,
  output logic [NR-1:0] div_o
);
  logic [1:0] sync_q;
  logic       rst_loc;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_loc = sync_q[1];

  for (genvar i = 0; i < NR; i++) begin : g_div
    localparam int R = path_ratio(PATH, i);
    if (R == 1) begin : g_pass
      assign div_o[i] = clk_i;
    end else begin : g_cnt
      ratio_div #(.N(R)) u_div (
        .clk_i (clk_i),
        .rst_n (rst_loc),
        .div_o (div_o[i])
      );
    end
  end

endmodule

// File: rtl/glitchless_sel.sv
module glitchless_sel #(
  parameter int          NL       = 27,
  parameter int          LW       = 5,
  parameter logic [LW-1:0] RST_LEAF = '0
) (
  input  logic          rst_n,
  input  logic [NL-1:0] leaf_i,
  input  logic [LW-1:0] want_i,
  output logic [LW-1:0] act_o,
  output logic          clk_o
);
  logic [LW-1:0] act_q, act_d;
  logic          upd_en;

  always_comb begin
    upd_en = (want_i != act_q);
    act_d  = upd_en ? want_i : act_q;
  end

  // taken up only on a falling edge of the running output
  always_ff @(negedge clk_o or negedge rst_n) begin
    if (!rst_n)      act_q <= RST_LEAF;
    else if (upd_en) act_q <= act_d;
  end

  assign clk_o = leaf_i[act_q];
  assign act_o = act_q;

endmodule

// File: rtl/clk_post_div.sv
module clk_post_div import clkdiv_pkg::*; #(
  parameter int NOUT = 4
) (
  input  logic                 rst_n,
  input  logic                 clk_sys,
  input  logic                 clk_cpu,
  input  logic                 clk_utl,
  input  logic                 clk_ref,
  input  logic [NOUT*SRCW-1:0] cfg_src,
  input  logic [NOUT*IDXW-1:0] cfg_idx,
  input  logic [1:0]           cfg_cpu_idx,
  input  logic [1:0]           cfg_f_idx,
  output logic [NOUT-1:0]      gen_clk,
  output logic                 cpu_clk,
  output logic                 f_clk,
  output logic                 ref_buf
);
  localparam int NSYS = path_count(0);
  localparam int NCPU = path_count(1);
  localparam int NUTL = path_count(2);
  localparam int NREF = path_count(3);

  logic [NSYS-1:0]  sys_v;
  logic [NCPU-1:0]  cpu_v;
  logic [NUTL-1:0]  utl_v;
  logic [NREF-1:0]  ref_v;
  logic [NLEAF-1:0] leaf;

  div_bank #(.PATH(0)) u_sys (.clk_i(clk_sys), .rst_n(rst_n), .div_o(sys_v));
  div_bank #(.PATH(1)) u_cpu (.clk_i(clk_cpu), .rst_n(rst_n), .div_o(cpu_v));
  div_bank #(.PATH(2)) u_utl (.clk_i(clk_utl), .rst_n(rst_n), .div_o(utl_v));
  div_bank #(.PATH(3)) u_ref (.clk_i(clk_ref), .rst_n(rst_n), .div_o(ref_v));

  assign leaf = {ref_v, utl_v, cpu_v, sys_v};

  localparam logic [LEAFW-1:0] SYS_DIV2 = LEAFW'(path_base(0) + 1);
  localparam logic [LEAFW-1:0] CPU_DIV2 = LEAFW'(path_base(1) + 1);

  logic [LEAFW-1:0] gen_want [NOUT];
  logic [LEAFW-1:0] gen_act  [NOUT];
  logic [LEAFW-1:0] cpu_want, f_want, cpu_act, f_act;

  always_comb begin
    cpu_want = leaf_of(SRC_CPU, IDXW'(cfg_cpu_idx));
    f_want   = (cfg_f_idx == 2'd3) ? SYS_DIV2 : LEAFW'(path_base(0) + 1 + int'(cfg_f_idx));
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_comb gen_want[g] = leaf_of(cfg_src[g*SRCW +: SRCW], cfg_idx[g*IDXW +: IDXW]);

    glitchless_sel #(.NL(NLEAF), .LW(LEAFW), .RST_LEAF(SYS_DIV2)) u_sel (
      .rst_n  (rst_n),
      .leaf_i (leaf),
      .want_i (gen_want[g]),
      .act_o  (gen_act[g]),
      .clk_o  (gen_clk[g])
    );

    if (g > 0) begin : g_skew
      // R9
      shared_leaf_same_clk_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (gen_act[g] == gen_act[0]) |-> (gen_clk[g] == gen_clk[0]));
    end
  end

  glitchless_sel #(.NL(NLEAF), .LW(LEAFW), .RST_LEAF(CPU_DIV2)) u_cpu_sel (
    .rst_n  (rst_n),
    .leaf_i (leaf),
    .want_i (cpu_want),
    .act_o  (cpu_act),
    .clk_o  (cpu_clk)
  );

  glitchless_sel #(.NL(NLEAF), .LW(LEAFW), .RST_LEAF(SYS_DIV2)) u_f_sel (
    .rst_n  (rst_n),
    .leaf_i (leaf),
    .want_i (f_want),
    .act_o  (f_act),
    .clk_o  (f_clk)
  );

  assign ref_buf = clk_ref;

  // R5
  cpu_leaf_in_path_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (int'(cpu_act) >= path_base(1)) && (int'(cpu_act) < path_base(2)));

  // R6
  f_leaf_in_sys_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (int'(f_act) >= 1) && (int'(f_act) <= 3));

endmodule

// File: tb/clk_post_div_test.sv
`timescale 1ns/1ps
module clk_post_div_test;
  logic        rst_n, clk_sys, clk_cpu, clk_utl, clk_ref;
  logic [7:0]  cfg_src;
  logic [19:0] cfg_idx;
  logic [1:0]  cfg_cpu_idx, cfg_f_idx;
  logic [3:0]  gen_clk;
  logic        cpu_clk, f_clk, ref_buf;

  int  n_chk, n_fail, mk;
  bit  done;
  logic probe;

  clk_post_div uut (
    .rst_n(rst_n), .clk_sys(clk_sys), .clk_cpu(clk_cpu), .clk_utl(clk_utl), .clk_ref(clk_ref),
    .cfg_src(cfg_src), .cfg_idx(cfg_idx), .cfg_cpu_idx(cfg_cpu_idx), .cfg_f_idx(cfg_f_idx),
    .gen_clk(gen_clk), .cpu_clk(cpu_clk), .f_clk(f_clk), .ref_buf(ref_buf)
  );

  initial clk_sys = 0;
  always #2   clk_sys = ~clk_sys;
  initial clk_cpu = 0;
  always #3   clk_cpu = ~clk_cpu;
  initial clk_utl = 0;
  always #5   clk_utl = ~clk_utl;
  initial clk_ref = 0;
  always #2.5 clk_ref = ~clk_ref;

  always_comb begin
    case (mk)
      4:       probe = cpu_clk;
      5:       probe = f_clk;
      6:       probe = ref_buf;
      default: probe = gen_clk[mk[1:0]];
    endcase
  end

  function automatic real src_per(input int s);
    case (s)
      0: return 4.0;
      1: return 6.0;
      2: return 10.0;
      default: return 5.0;
    endcase
  endfunction

  function automatic int tbl_count(input int s);
    case (s)
      0: return 18;
      1: return 3;
      2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_ratio(input int s, input int i);
    int sys_r [18] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104};
    if (i >= tbl_count(s)) return 2;
    if (s == 0) return sys_r[i];
    return 1 << i;
  endfunction

  function automatic bit near(input real a, input real b);
    return ((a - b) < 0.01) && ((b - a) < 0.01);
  endfunction

  task automatic chk(input bit ok, input string req, input real act, input real expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f at %0t", req, act, expv, $realtime);
    end
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge probe) t0 = $realtime;
    @(negedge probe) t1 = $realtime;
    @(posedge probe) t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  // wait for the change to be taken up, skip one edge, then measure
  task automatic settle_measure(input real ep, input string req);
    real per, hi;
    @(negedge probe);
    @(posedge probe);
    measure(per, hi);
    chk(near(per, ep), req, per, ep);
    chk(near(hi, ep / 2.0), "R3", hi, ep / 2.0);
  endtask

  task automatic run_all_same(input int s, input int i);
    logic [1:0] sv;
    logic [4:0] iv;
    real ep;
    bit eq;
    string req;
    sv = s[1:0];
    iv = i[4:0];
    mk = (s + i) % 4;
    #1;
    cfg_src = {4{sv}};
    cfg_idx = {4{iv}};
    ep  = src_per(s) * exp_ratio(s, i);
    req = (i >= tbl_count(s)) ? "R4" : ((s == 0) ? "R1" : "R2");
    settle_measure(ep, req);
    eq = 1;
    for (int n = 0; n < 6; n++) begin
      #0.9;
      if (!(gen_clk == 4'b0000 || gen_clk == 4'b1111)) eq = 0;
    end
    chk(eq, "R9", real'(gen_clk), 0.0);
  endtask

  initial begin
    bit quiet, hold;
    real per, hi, t;
    n_chk = 0; n_fail = 0; done = 0; mk = 0;
    rst_n = 0;
    cfg_src = '0;
    cfg_idx = {4{5'd1}};
    cfg_cpu_idx = 2'd1;
    cfg_f_idx = 2'd0;

    // R10: quiet while reset is held
    quiet = 1;
    for (int n = 0; n < 8; n++) begin
      #5.3;
      if (gen_clk !== 4'b0000 || cpu_clk !== 1'b0 || f_clk !== 1'b0) quiet = 0;
    end
    chk(quiet, "R10", real'({gen_clk, cpu_clk, f_clk}), 0.0);
    chk(ref_buf === clk_ref, "R7", real'(ref_buf), real'(clk_ref));
    #8.1;
    rst_n = 1;
    #40;

    // R1 R2 R3 R4 R9: sweep of every legal pair plus out-of-range indices
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < tbl_count(s); i++)
        run_all_same(s, i);
    run_all_same(0, 18);
    run_all_same(0, 31);
    run_all_same(1, 3);
    run_all_same(1, 31);
    run_all_same(2, 4);
    run_all_same(3, 2);

    // R2: four different sources at once (sys/13, cpu/4, utl/8, ref/2)
    cfg_src = {2'd3, 2'd2, 2'd1, 2'd0};
    cfg_idx = {5'd1, 5'd3, 5'd2, 5'd9};
    mk = 0; #1; settle_measure(52.0, "R1");
    mk = 1; #1; settle_measure(24.0, "R2");
    mk = 2; #1; settle_measure(80.0, "R2");
    mk = 3; #1; settle_measure(10.0, "R2");

    // R5: CPU clock selector
    for (int i = 0; i < 4; i++) begin
      mk = 4; #1;
      cfg_cpu_idx = i[1:0];
      settle_measure(6.0 * ((i < 3) ? (1 << i) : 2), "R5");
    end

    // R6: fixed-function clock selector
    for (int i = 0; i < 4; i++) begin
      mk = 5; #1;
      cfg_f_idx = i[1:0];
      settle_measure(4.0 * ((i < 3) ? (i + 2) : 2), "R6");
    end

    // R7: reference buffer
    mk = 6; #1;
    measure(per, hi);
    chk(near(per, 5.0), "R7", per, 5.0);
    chk(ref_buf === clk_ref, "R7", real'(ref_buf), real'(clk_ref));

    // R8: change /104 -> /1 right after a rising edge; high phase stays whole
    mk = 0; #1;
    cfg_src = '0;
    cfg_idx = {4{5'd17}};
    @(negedge probe);
    @(posedge probe);
    @(posedge probe) t = $realtime;
    #0.5;
    cfg_idx = {4{5'd0}};
    hold = 1;
    for (int n = 0; n < 41; n++) begin
      #5;
      if (probe !== 1'b1) hold = 0;
    end
    chk(hold, "R8", real'(probe), 1.0);
    #10;
    measure(per, hi);
    chk(near(per, 4.0), "R8", per, 4.0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule